// File: doc/BRIEF.md
# Return-to-Zero Handshake FIFO

This block is a first-in first-out buffer whose two ports speak a four-phase request/acknowledge protocol instead of exposing full and empty flags. A sender places a word on `snd_data` and raises `snd_req`. The buffer answers with `snd_ack` once the word is stored. The sender then drops its request, and the buffer drops its acknowledge. The receiving side works the same way with `rcv_req` and `rcv_ack`. The word at the head of the queue is always present on `rcv_data`, before any request arrives. Back-pressure comes only from holding back an acknowledge: a put is not acknowledged while no slot is free, and a get is not acknowledged while nothing is stored.

Inside, the storage is a ring of slots. Each slot has a validity bit. A one-hot put token and a one-hot get token travel around the ring. A slot is filled and marked valid on the rising phase of a put. The put token moves on only when the put request returns to zero. A slot is freed, and the get token moves on, only when the get request returns to zero. Both request lines come from other timing domains, so each passes through a synchronizer chain clocked by the single system clock.

Top module: `hs_fifo`

## Requirements
- R1: `snd_ack` rises only while a synchronized `snd_req` is high and a slot is free. It then stays high until `snd_req` has fallen, and falls after that.
- R2: `rcv_ack` rises only while a synchronized `rcv_req` is high and a word is stored. While `rcv_ack` is high, `rcv_data` holds the word being dequeued without change. `rcv_ack` falls after `rcv_req` has fallen.
- R3: When DEPTH words are stored, a new put request gets no `snd_ack` until a get handshake has completed.
- R4: While the buffer is empty, a get request gets no `rcv_ack`. The acknowledge comes once a word has been stored.
- R5: Exactly one word moves per complete four-phase cycle on each port. A request held high after its acknowledge never causes a second transfer.
- R6: The head word appears on `rcv_data` once it is stored, with `rcv_req` low.
- R7: A stored slot is released only when `rcv_req` returns to zero. While a get request stays high, a waiting put into a full buffer is not acknowledged.
- R8: Words leave in the order they entered, also when the tokens wrap around the ring several times.
- R9: After reset all slots are empty, both tokens sit in slot 0, and `snd_ack` and `rcv_ack` are low.
- R10: With the default two-stage synchronizer, a request raised between clock edges is acknowledged at the third rising edge after it rises, and not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples both request lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| snd_req | input | 1 | Put request, four-phase |
| snd_data | input | WIDTH | Word to enqueue, held stable while `snd_req` is high |
| snd_ack | output | 1 | Put acknowledge: the word is stored |
| rcv_req | input | 1 | Get request, four-phase |
| rcv_data | output | WIDTH | Head word of the queue |
| rcv_ack | output | 1 | Get acknowledge: `rcv_data` holds a dequeued word |

## Verification
A slot whose validity bit is wrong shows at the ports within one handshake. A slot wrongly left valid makes a later get return stale data, or leaves a put without an acknowledge one word short of capacity. A slot wrongly cleared lets a put overwrite an unread word, which the order check then catches. A token that moves on the rising phase instead of the falling one shifts every following word by one slot. That shows as an ordering error, or as a put acknowledged while the get request is still held, within the same or the next handshake. Synchronizer depth and held-request behaviour appear directly as acknowledge latency, and as extra or missing words when the queue is drained.

// File: rtl/hs_fifo_pkg.sv
`timescale 1ns/1ps
package hs_fifo_pkg;
   // Phase of one four-phase handshake on a port.
   typedef enum logic {
      HS_IDLE = 1'b0,   // waiting for a request with a usable slot
      HS_HOLD = 1'b1    // acknowledged, waiting for the request to return to zero
   } hs_phase_e;
endpackage

// File: rtl/hs_sync.sv
`timescale 1ns/1ps
module hs_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("hs_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d_i};
   end

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/hs_cell.sv
`timescale 1ns/1ps
module hs_cell #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_i,    // put accepted into this slot (rising phase)
   input  logic             clr_i,    // get completed from this slot (falling phase)
   input  logic [WIDTH-1:0] wdata_i,
   output logic             valid_o,
   output logic [WIDTH-1:0] data_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         data_o  <= '0;
      end else begin
         if (set_i) begin
            valid_o <= 1'b1;
            data_o  <= wdata_i;
         end else if (clr_i) begin
            valid_o <= 1'b0;
         end
      end
   end

   // R3: a slot is never written while it holds an unread word
   a_r3_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |-> !valid_o);
   // R7: a slot is released only when it holds a word
   a_r7_clear_only_valid: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |-> valid_o);
   // R5: fill and release of one slot never coincide
   a_r5_set_clr_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(set_i && clr_i));
endmodule

// File: rtl/hs_port_ctrl.sv
`timescale 1ns/1ps
module hs_port_ctrl
   import hs_fifo_pkg::*;
#(
   parameter int DEPTH  = 4,
   parameter bit IS_PUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_s_i,       // synchronized request
   input  logic [DEPTH-1:0] cell_valid_i,
   output logic             ack_o,
   output logic [DEPTH-1:0] tok_o,         // one-hot token position
   output logic             grant_o,       // rising-phase acceptance, one cycle
   output logic             release_o      // falling-phase completion, one cycle
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("hs_port_ctrl: DEPTH must be at least 2");
   end

   hs_phase_e phase;
   logic      slot_ok;
   logic      tok_valid;

   assign tok_valid = |(cell_valid_i & tok_o);

   if (IS_PUT) begin : g_put_side
      assign slot_ok = !tok_valid;   // put needs an empty slot under the token
   end else begin : g_get_side
      assign slot_ok = tok_valid;    // get needs a stored word under the token
   end

   assign grant_o   = (phase == HS_IDLE) && req_s_i && slot_ok;
   assign release_o = (phase == HS_HOLD) && !req_s_i;
   assign ack_o     = (phase == HS_HOLD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= HS_IDLE;
         tok_o <= DEPTH'(1);
      end else begin
         if (grant_o) phase <= HS_HOLD;
         else if (release_o) begin
            phase <= HS_IDLE;
            tok_o <= {tok_o[DEPTH-2:0], tok_o[DEPTH-1]};
         end
      end
   end

   // R1/R2: the acknowledge rises only in answer to a high request
   a_r1_ack_rise_on_req: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_o) |-> $past(req_s_i));
   // R1/R2: the acknowledge falls only after the request has returned to zero
   a_r2_ack_fall_on_idle: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ack_o) |-> !$past(req_s_i));
   // R5: a held request keeps the acknowledge up and moves nothing more
   a_r5_hold_while_req: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_o && req_s_i) |=> (ack_o && $stable(tok_o)));
   // R9: exactly one token position at all times
   a_r9_token_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(tok_o) == 1);
endmodule

// File: rtl/hs_fifo.sv
`timescale 1ns/1ps
module hs_fifo #(
   parameter int DEPTH       = 4,
   parameter int WIDTH       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             snd_req,
   input  logic [WIDTH-1:0] snd_data,
   output logic             snd_ack,
   input  logic             rcv_req,
   output logic [WIDTH-1:0] rcv_data,
   output logic             rcv_ack
);
   if (WIDTH < 1) begin : g_bad_width
      $error("hs_fifo: WIDTH must be at least 1");
   end

   logic             snd_req_s, rcv_req_s;
   logic [DEPTH-1:0] cell_valid;
   logic [WIDTH-1:0] cell_data [DEPTH];
   logic [DEPTH-1:0] put_tok, get_tok;
   logic             put_grant, put_release;
   logic             get_grant, get_release;

   hs_sync #(.STAGES(SYNC_STAGES)) u_snd_sync (
      .clk(clk), .rst_n(rst_n), .d_i(snd_req), .q_o(snd_req_s));
   hs_sync #(.STAGES(SYNC_STAGES)) u_rcv_sync (
      .clk(clk), .rst_n(rst_n), .d_i(rcv_req), .q_o(rcv_req_s));

   hs_port_ctrl #(.DEPTH(DEPTH), .IS_PUT(1'b1)) u_put_ctrl (
      .clk(clk), .rst_n(rst_n), .req_s_i(snd_req_s), .cell_valid_i(cell_valid),
      .ack_o(snd_ack), .tok_o(put_tok), .grant_o(put_grant), .release_o(put_release));

   hs_port_ctrl #(.DEPTH(DEPTH), .IS_PUT(1'b0)) u_get_ctrl (
      .clk(clk), .rst_n(rst_n), .req_s_i(rcv_req_s), .cell_valid_i(cell_valid),
      .ack_o(rcv_ack), .tok_o(get_tok), .grant_o(get_grant), .release_o(get_release));

   for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      hs_cell #(.WIDTH(WIDTH)) u_cell (
         .clk(clk), .rst_n(rst_n),
         .set_i(put_grant && put_tok[i]),
         .clr_i(get_release && get_tok[i]),
         .wdata_i(snd_data),
         .valid_o(cell_valid[i]),
         .data_o(cell_data[i]));
   end

   // Head word: the slot holding the get token drives the output at all times.
   always_comb begin
      rcv_data = '0;
      for (int i = 0; i < DEPTH; i++)
         if (get_tok[i]) rcv_data = cell_data[i];
   end

   // R2: the dequeued word does not change while the get acknowledge is high
   a_r2_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (rcv_ack && $past(rcv_ack)) |-> $stable(rcv_data));
   // R4: no get acknowledge while every slot was empty
   a_r4_no_ack_empty: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rcv_ack) |-> $past(|cell_valid));
   // R3: no put acknowledge while every slot was full
   a_r3_no_ack_full: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(snd_ack) |-> !$past(&cell_valid));
   // R8: the get grant fires only with the get token on a stored slot
   a_r8_get_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
      get_grant |-> |(get_tok & cell_valid));
endmodule

// File: tb/hs_fifo_bench.sv
`timescale 1ns/1ps
module hs_fifo_bench;
   localparam int DEPTH = 4;
   localparam int WIDTH = 8;
   localparam int LIM   = 40;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             snd_req = 1'b0;
   logic [WIDTH-1:0] snd_data = '0;
   logic             snd_ack;
   logic             rcv_req = 1'b0;
   logic [WIDTH-1:0] rcv_data;
   logic             rcv_ack;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   hs_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH), .SYNC_STAGES(2)) u_hs_fifo (
      .clk(clk), .rst_n(rst_n),
      .snd_req(snd_req), .snd_data(snd_data), .snd_ack(snd_ack),
      .rcv_req(rcv_req), .rcv_data(rcv_data), .rcv_ack(rcv_ack));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_snd(input logic v, output int n);
      n = 0;
      while (snd_ack !== v && n < LIM) begin @(negedge clk); n++; end
   endtask

   task automatic wait_rcv(input logic v, output int n);
      n = 0;
      while (rcv_ack !== v && n < LIM) begin @(negedge clk); n++; end
   endtask

   task automatic put_item(input logic [WIDTH-1:0] d);
      int n;
      @(negedge clk);
      snd_data = d; snd_req = 1'b1;
      wait_snd(1'b1, n);
      check(n < LIM, "R1 put acknowledged", n, 0);
      snd_req = 1'b0;
      wait_snd(1'b0, n);
      check(n < LIM, "R1 put ack returns to zero", n, 0);
   endtask

   task automatic get_item(input logic [WIDTH-1:0] exp, input string req);
      int n;
      @(negedge clk);
      rcv_req = 1'b1;
      wait_rcv(1'b1, n);
      check(n < LIM && rcv_data == exp, req, int'(rcv_data), int'(exp));
      rcv_req = 1'b0;
      wait_rcv(1'b0, n);
      check(n < LIM, "R2 get ack returns to zero", n, 0);
   endtask

   task automatic t_reset();
      check(snd_ack == 1'b0, "R9 snd_ack low after reset", snd_ack, 0);
      check(rcv_ack == 1'b0, "R9 rcv_ack low after reset", rcv_ack, 0);
   endtask

   task automatic t_latency();
      int n;
      @(negedge clk);
      snd_data = 8'hA1; snd_req = 1'b1;
      @(negedge clk);
      check(snd_ack == 1'b0, "R10 no ack after first edge", snd_ack, 0);
      @(negedge clk);
      check(snd_ack == 1'b0, "R10 no ack after second edge", snd_ack, 0);
      @(negedge clk);
      check(snd_ack == 1'b1, "R10 ack at third edge", snd_ack, 1);
      snd_req = 1'b0;
      wait_snd(1'b0, n);
      repeat (5) @(negedge clk);
      check(rcv_data == 8'hA1 && rcv_req == 1'b0, "R6 head word before request",
            int'(rcv_data), 'hA1);
      get_item(8'hA1, "R2 first word returned");
   endtask

   task automatic t_empty();
      int n;
      @(negedge clk);
      rcv_req = 1'b1;
      repeat (20) @(negedge clk);
      check(rcv_ack == 1'b0, "R4 no get ack while empty", rcv_ack, 0);
      put_item(8'h5C);
      wait_rcv(1'b1, n);
      check(n < LIM && rcv_data == 8'h5C, "R4 get ack after word arrives",
            int'(rcv_data), 'h5C);
      rcv_req = 1'b0;
      wait_rcv(1'b0, n);
   endtask

   task automatic t_order();
      for (int k = 0; k < 3; k++) begin
         for (int i = 0; i < DEPTH; i++) put_item(WIDTH'(k * 16 + i + 1));
         for (int i = 0; i < DEPTH; i++) get_item(WIDTH'(k * 16 + i + 1), "R8 order across wrap");
      end
      put_item(8'h61); put_item(8'h62);
      get_item(8'h61, "R8 interleaved order");
      put_item(8'h63);
      get_item(8'h62, "R8 interleaved order");
      get_item(8'h63, "R8 interleaved order");
   endtask

   task automatic t_full();
      int n;
      for (int i = 0; i < DEPTH; i++) put_item(WIDTH'(8'h80 + i));
      @(negedge clk);
      snd_data = 8'hEE; snd_req = 1'b1;
      repeat (20) @(negedge clk);
      check(snd_ack == 1'b0, "R3 no put ack while full", snd_ack, 0);
      get_item(8'h80, "R3 head of full buffer");
      wait_snd(1'b1, n);
      check(n < LIM, "R3 put ack after a get frees a slot", n, 0);
      snd_req = 1'b0;
      wait_snd(1'b0, n);
      for (int i = 1; i < DEPTH; i++) get_item(WIDTH'(8'h80 + i), "R3 drain order");
      get_item(8'hEE, "R3 late word stored");
   endtask

   task automatic t_release();
      int n;
      for (int i = 0; i < DEPTH; i++) put_item(WIDTH'(8'h90 + i));
      @(negedge clk);
      snd_data = 8'h77; snd_req = 1'b1;
      rcv_req = 1'b1;
      wait_rcv(1'b1, n);
      check(n < LIM && rcv_data == 8'h90, "R7 head word on get ack", int'(rcv_data), 'h90);
      repeat (15) @(negedge clk);
      check(snd_ack == 1'b0, "R7 slot kept while get request high", snd_ack, 0);
      rcv_req = 1'b0;
      wait_rcv(1'b0, n);
      wait_snd(1'b1, n);
      check(n < LIM, "R7 slot freed after get request falls", n, 0);
      snd_req = 1'b0;
      wait_snd(1'b0, n);
      for (int i = 1; i < DEPTH; i++) get_item(WIDTH'(8'h90 + i), "R7 drain order");
      get_item(8'h77, "R7 waiting word stored");
   endtask

   task automatic t_single();
      int n;
      @(negedge clk);
      snd_data = 8'h31; snd_req = 1'b1;
      wait_snd(1'b1, n);
      repeat (30) @(negedge clk);
      check(snd_ack == 1'b1, "R5 ack held with request", snd_ack, 1);
      snd_req = 1'b0;
      wait_snd(1'b0, n);
      get_item(8'h31, "R5 single held put");
      @(negedge clk);
      rcv_req = 1'b1;
      repeat (15) @(negedge clk);
      check(rcv_ack == 1'b0, "R5 held put stored one word only", rcv_ack, 0);
      rcv_req = 1'b0;
      repeat (5) @(negedge clk);
      put_item(8'h41); put_item(8'h42);
      @(negedge clk);
      rcv_req = 1'b1;
      wait_rcv(1'b1, n);
      check(rcv_data == 8'h41, "R5 held get first word", int'(rcv_data), 'h41);
      repeat (30) @(negedge clk);
      check(rcv_ack == 1'b1 && rcv_data == 8'h41, "R5 held get moves nothing",
            int'(rcv_data), 'h41);
      rcv_req = 1'b0;
      wait_rcv(1'b0, n);
      get_item(8'h42, "R5 second word after held get");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_latency();
      t_empty();
      t_order();
      t_full();
      t_release();
      t_single();
      repeat (5) @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog: actual=expired expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule